// File: doc/BRIEF.md
# Selective Harmonic Elimination Staircase Generator

This block drives one phase leg of an m-level converter with a low-frequency staircase. The switching angles are solved offline. A phase accumulator advances by a programmable increment on every clock and wraps once per fundamental period. Quarter-wave and half-wave symmetry fold each phase position into the first quarter. There it is compared against the set of stored angles chosen by a modulation-index selector. The signed output level equals the number of angles passed, with its sign flipped in the second half of the period. For m levels there are (m-1)/2 angles per quarter. These angles remove (m-3)/2 low-order harmonics and set the fundamental amplitude. Each level step therefore switches only once per quarter period.

A host loads angle sets through a write port that takes a whole set at once. A set whose angles are not strictly ascending, or that reaches a quarter period, is discarded and flagged. A change of modulation index on the selector input is held back until the accumulator next wraps. This keeps the symmetry of the waveform intact. The sequencer has two states. `ST_IDLE` holds the accumulator at zero and the output at level zero. `ST_RUN` advances the phase. The transition `START` (ST_IDLE to ST_RUN, taken when `run` is high) latches the selector. The transition `STOP` (ST_RUN to ST_IDLE, taken when `run` is low) clears the accumulator.

Top module: `shs_staircase`

## Requirements
- R1: After reset, `level` is 0, `wr_reject` is 0, the sequencer is in ST_IDLE, and every table entry holds angles k = 0..NANG-1 equal to (k+1)*Q/(NANG+1). Q = 2^(PHASE_W-2) is one quarter period.
- R2: For an accumulator value a in the first quarter (a[PHASE_W-1:PHASE_W-2] = 0), with q = a mod Q, the level is the count of active angles that are less than or equal to q.
- R3: In the second quarter (top bits 01), the position is mirrored to x = Q - q, and the level is the count of active angles that are less than or equal to x.
- R4: In the third and fourth quarters (top bit 1), the level is the negation of the level that the same lower bits give in the first and second quarters.
- R5: A write (`wr_en` high) stores the set on `wr_angles` into entry `wr_sel` when every angle is below Q and the angles are strictly ascending. Angle k sits at bits [k*(PHASE_W-1) +: PHASE_W-1], with k = 0 being the lowest angle.
- R6: A write that breaks R5's rule leaves the entry unchanged. It raises `wr_reject` for exactly the one cycle after the write edge.
- R7: The active entry is taken from `sel_in` on the START edge and on each edge where the accumulator wraps. At any other edge, changes on `sel_in` have no effect.
- R8: `inc_we` loads `inc_val` into the increment register. In ST_RUN the accumulator adds the increment modulo 2^PHASE_W on every edge, beginning one edge after START. `level` is registered and shows the value computed from the accumulator of the previous cycle.
- R9: With `run` low, the accumulator is held at 0. `level` is 0 from the second edge after `run` falls, and also on the first edge after START.
- R10: `level` always lies within -NANG..+NANG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables the phase sequencer |
| inc_we | input | 1 | Load strobe for the phase increment |
| inc_val | input | PHASE_W | Phase increment per clock |
| sel_in | input | SEL_W | Requested modulation-index entry |
| wr_en | input | 1 | Angle-set write strobe |
| wr_sel | input | SEL_W | Entry to write |
| wr_angles | input | NANG*(PHASE_W-1) | Packed angle set, lowest angle in low bits |
| wr_reject | output | 1 | One-cycle flag for a discarded set |
| level | output | LVL_W (signed) | Staircase level |

## Verification
The phase visible after the START edge is zero. After edge n of the run it is (n-1) times the increment. The level that reads back after edge n belongs to the accumulator value of edge n-1. The bench therefore compares the sample taken before edge j+1 with the arithmetic result for (j-2) times the increment, and expects 0 at j = 1. `wr_reject` is due one edge after the write. The bench samples it at the next falling edge, and again one cycle later to confirm the pulse has ended. Index changes are presented half a period ahead of each wrap, so that R7's deferral is exercised. Level zero after a stop is checked two edges after `run` falls.

// File: rtl/shs_pkg.sv
package shs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/shs_angle_table.sv
module shs_angle_table #(
    parameter int PHASE_W = 16,
    parameter int NANG    = 3,
    parameter int NSEL    = 4,
    localparam int SEL_W   = $clog2(NSEL),
    localparam int AW      = PHASE_W - 1,
    localparam int QW      = PHASE_W - 2,
    localparam int QUARTER = 1 << QW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [NANG*AW-1:0]   wr_angles,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [NANG*QW-1:0]   rd_angles,
    output logic                 wr_reject
);
    logic [NANG*QW-1:0] mem [NSEL];
    logic [NANG*QW-1:0] wr_pack;
    logic               entry_ok;
    logic [AW-1:0]      prev_ang;
    logic [AW-1:0]      cur_ang;

    // Validity: every angle below a quarter, strictly ascending.
    always_comb begin
        entry_ok = 1'b1;
        prev_ang = '0;
        cur_ang  = '0;
        wr_pack  = '0;
        for (int k = 0; k < NANG; k++) begin
            cur_ang = wr_angles[k*AW +: AW];
            if (cur_ang >= AW'(QUARTER)) begin
                entry_ok = 1'b0;
            end
            if ((k != 0) && (cur_ang <= prev_ang)) begin
                entry_ok = 1'b0;
            end
            prev_ang = cur_ang;
            wr_pack[k*QW +: QW] = cur_ang[QW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_reject <= 1'b0;
            for (int s = 0; s < NSEL; s++) begin
                for (int k = 0; k < NANG; k++) begin
                    mem[s][k*QW +: QW] <= QW'(((k + 1) * QUARTER) / (NANG + 1));
                end
            end
        end else begin
            wr_reject <= wr_en && !entry_ok;
            if (wr_en && entry_ok) begin
                mem[wr_sel] <= wr_pack;
            end
        end
    end

    assign rd_angles = mem[rd_sel];
endmodule

// File: rtl/shs_phase_ctrl.sv
module shs_phase_ctrl
    import shs_pkg::*;
#(
    parameter int PHASE_W  = 16,
    parameter int SEL_W    = 2,
    parameter int INC_INIT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               inc_we,
    input  logic [PHASE_W-1:0] inc_val,
    input  logic [SEL_W-1:0]   sel_in,
    output logic [PHASE_W-1:0] phase,
    output logic [SEL_W-1:0]   act_sel,
    output logic               running
);
    seq_state_e         state_q;
    seq_state_e         state_d;
    logic [PHASE_W-1:0] inc_q;
    logic [PHASE_W:0]   sum;

    assign sum = {1'b0, phase} + {1'b0, inc_q};

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run)  state_d = ST_RUN;   // START
            ST_RUN:  if (!run) state_d = ST_IDLE;  // STOP
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers driven by state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            act_sel <= '0;
            inc_q   <= PHASE_W'(INC_INIT);
        end else begin
            if (inc_we) inc_q <= inc_val;
            unique case (state_q)
                ST_IDLE: begin
                    phase <= '0;
                    if (run) act_sel <= sel_in;
                end
                ST_RUN: begin
                    if (!run) begin
                        phase <= '0;
                    end else begin
                        phase <= sum[PHASE_W-1:0];
                        if (sum[PHASE_W]) act_sel <= sel_in;
                    end
                end
                default: phase <= '0;
            endcase
        end
    end

    assign running = (state_q == ST_RUN);
endmodule

// File: rtl/shs_level_map.sv
module shs_level_map #(
    parameter int PHASE_W = 16,
    parameter int NANG    = 3,
    parameter int LVL_W   = 3,
    localparam int QW      = PHASE_W - 2,
    localparam int QUARTER = 1 << QW
) (
    input  logic [PHASE_W-1:0]      phase,
    input  logic [NANG*QW-1:0]      angles,
    output logic signed [LVL_W-1:0] level_d
);
    logic [1:0]              quad;
    logic [QW-1:0]           qpos;
    logic [QW:0]             fold;
    logic signed [LVL_W-1:0] cnt;

    assign quad = phase[PHASE_W-1:PHASE_W-2];
    assign qpos = phase[QW-1:0];
    // Second and fourth quarters are mirrored about the peak.
    assign fold = quad[0] ? ((QW+1)'(QUARTER) - {1'b0, qpos}) : {1'b0, qpos};

    always_comb begin
        cnt = '0;
        for (int k = 0; k < NANG; k++) begin
            if (fold >= {1'b0, angles[k*QW +: QW]}) cnt = cnt + LVL_W'(1);
        end
        level_d = quad[1] ? -cnt : cnt;
    end
endmodule

// File: rtl/shs_staircase.sv
module shs_staircase #(
    parameter int LEVELS   = 7,
    parameter int PHASE_W  = 16,
    parameter int NSEL     = 4,
    parameter int INC_INIT = 256,
    localparam int NANG  = (LEVELS - 1) / 2,
    localparam int SEL_W = $clog2(NSEL),
    localparam int AW    = PHASE_W - 1,
    localparam int QW    = PHASE_W - 2,
    localparam int LVL_W = $clog2(NANG + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    inc_we,
    input  logic [PHASE_W-1:0]      inc_val,
    input  logic [SEL_W-1:0]        sel_in,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [NANG*AW-1:0]      wr_angles,
    output logic                    wr_reject,
    output logic signed [LVL_W-1:0] level
);
    logic [PHASE_W-1:0]      phase;
    logic [SEL_W-1:0]        act_sel;
    logic                    running;
    logic [NANG*QW-1:0]      angles;
    logic signed [LVL_W-1:0] level_d;

    shs_phase_ctrl #(
        .PHASE_W (PHASE_W),
        .SEL_W   (SEL_W),
        .INC_INIT(INC_INIT)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .inc_we (inc_we),
        .inc_val(inc_val),
        .sel_in (sel_in),
        .phase  (phase),
        .act_sel(act_sel),
        .running(running)
    );

    shs_angle_table #(
        .PHASE_W(PHASE_W),
        .NANG   (NANG),
        .NSEL   (NSEL)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_angles(wr_angles),
        .rd_sel   (act_sel),
        .rd_angles(angles),
        .wr_reject(wr_reject)
    );

    shs_level_map #(
        .PHASE_W(PHASE_W),
        .NANG   (NANG),
        .LVL_W  (LVL_W)
    ) u_map (
        .phase  (phase),
        .angles (angles),
        .level_d(level_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       level <= '0;
        else if (running) level <= level_d;
        else              level <= '0;
    end
endmodule

// File: rtl/shs_staircase_chk.sv
module shs_staircase_chk #(
    parameter int PHASE_W = 16,
    parameter int NANG    = 3,
    parameter int SEL_W   = 2,
    parameter int LVL_W   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    wr_reject,
    input logic signed [LVL_W-1:0] level,
    input logic                    running,
    input logic [PHASE_W-1:0]      phase,
    input logic [SEL_W-1:0]        act_sel
);
    assert_reject_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(wr_en));

    assert_level_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LVL_W'(NANG)) && (level >= -(LVL_W'(NANG))));

    assert_idle_level_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (level == '0));

    assert_idle_phase_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (phase == '0));

    assert_first_half_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !phase[PHASE_W-1]) |=> (level >= 0));

    assert_second_half_nonpos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase[PHASE_W-1]) |=> (level <= 0));

    assert_select_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_sel) |-> (!$past(running) || (phase < $past(phase))));
endmodule

bind shs_staircase shs_staircase_chk #(
    .PHASE_W(PHASE_W),
    .NANG   (NANG),
    .SEL_W  (SEL_W),
    .LVL_W  (LVL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_reject(wr_reject),
    .level    (level),
    .running  (running),
    .phase    (phase),
    .act_sel  (act_sel)
);

// File: tb/sim_shs_staircase.sv
module sim_shs_staircase;
    localparam int PW = 16;
    localparam int Q  = 1 << (PW - 2);
    localparam int NA = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run = 1'b0;
    logic              inc_we = 1'b0;
    logic [PW-1:0]     inc_val = '0;
    logic [1:0]        sel_in = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [NA*15-1:0]  wr_angles = '0;
    logic              wr_reject;
    logic signed [2:0] level;

    int checks = 0;
    int errors = 0;
    int tbl [4][3];
    int plan [8];

    always #10 clk = ~clk;

    shs_staircase u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .inc_we(inc_we), .inc_val(inc_val),
        .sel_in(sel_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_angles(wr_angles),
        .wr_reject(wr_reject), .level(level)
    );

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_level(int a, int s);
        int quad = (a >> 14) & 3;
        int q = a & (Q - 1);
        int x = (quad & 1) ? (Q - q) : q;
        int cnt = 0;
        for (int k = 0; k < NA; k++) if (x >= tbl[s][k]) cnt++;
        return (quad >= 2) ? -cnt : cnt;
    endfunction

    task automatic write_set(int s, int a0, int a1, int a2);
        bit ok;
        ok = (a0 < Q) && (a1 < Q) && (a2 < Q) && (a0 < a1) && (a1 < a2);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = 2'(s);
        wr_angles = {15'(a2), 15'(a1), 15'(a0)};
        @(negedge clk);
        wr_en = 1'b0;
        check_eq(ok ? "R5 accept" : "R6 reject flag", int'(wr_reject), ok ? 0 : 1);
        if (ok) begin
            tbl[s][0] = a0; tbl[s][1] = a1; tbl[s][2] = a2;
        end
        @(negedge clk);
        check_eq("R6 single-cycle flag", int'(wr_reject), 0);
    endtask

    function automatic int per_of(longint j, int inc);
        return int'((j * inc) >> PW);
    endfunction

    task automatic run_test(int inc, int nper);
        int k, n, exp, a, p;
        string tag;
        @(negedge clk);
        inc_we = 1'b1;
        inc_val = PW'(inc);
        @(negedge clk);
        inc_we = 1'b0;
        k = ((1 << PW) / inc) / 2;
        n = nper * ((1 << PW) / inc);
        run = 1'b1;
        sel_in = 2'(plan[per_of(k, inc)]);
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            sel_in = 2'(plan[per_of(j + k, inc)]);
            if (j == 1) begin
                check_eq("R9 first edge after START", int'(level), 0);
            end else begin
                a = int'((longint'(j - 2) * inc) & 64'hFFFF);
                p = per_of(j - 2, inc);
                exp = model_level(a, plan[p]);
                if (p > 0 && plan[p] != plan[p - 1]) tag = "R8 R7 R2 R3 R4 after index change";
                else if (a < Q) tag = "R8 R2 first quarter";
                else if (a < 2 * Q) tag = "R8 R3 second quarter";
                else tag = "R8 R4 second half";
                check_eq(tag, int'(level), exp);
                check_eq("R10 range", int'(level >= -NA && level <= NA), 1);
            end
        end
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_eq("R9 level after stop", int'(level), 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < NA; k++) tbl[s][k] = ((k + 1) * Q) / (NA + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 reset level", int'(level), 0);
        check_eq("R1 reset reject", int'(wr_reject), 0);

        // R1: run on the reset table contents
        for (int i = 0; i < 8; i++) plan[i] = 0;
        run_test(256, 3);

        write_set(1, 1000, 5000, 9000);
        write_set(2, 0, 1, 16383);
        write_set(3, 3000, 3001, 15000);
        write_set(1, 5000, 5000, 6000);
        write_set(1, 100, 200, 16384);
        write_set(2, 9000, 5000, 100);
        write_set(3, 20000, 25000, 30000);

        plan = '{1, 2, 3, 1, 0, 2, 3, 1};
        run_test(1000, 5);
        plan = '{2, 3, 0, 1, 3, 2, 1, 0};
        run_test(4099, 6);
        plan = '{3, 1, 2, 0, 0, 0, 0, 0};
        run_test(64, 2);
        plan = '{2, 2, 2, 2, 2, 2, 2, 2};
        run_test(1, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule